// File: doc/BRIEF.md
# Power Mode and Reset Sequencer

This block decides which operating mode a battery-backed metering controller is in. It watches three conditions: the external reset pin, the output of a comparator that reports whether system power is good, and a flag that says whether a backup battery is present. From these it selects one of four modes. In MISSION, full power is present and the PLL is locked. In BROWNOUT, the controller runs from the battery. LCD is a display-only battery state. In SLEEP, the processor is held.

The block times two events by counting cycles of the slow 32 kHz clock: the release from reset and the PLL lock after power returns. Its outputs are:
- a wake signal that lets the processor run;
- a PLL-ready bit;
- a 2-bit mode code;
- a level that holds configuration registers at their defaults;
- a one-cycle interrupt when the controller returns from battery operation;
- the enable for the hardware watchdog.

The power-good and battery inputs pass through a synchronizer before the state machine uses them. The LCD mode is entered only on an external request.

Top module: `pwr_mode_seq`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block resets to the held state. In that state `wake_o`=0, `pll_ok_o`=0, `mode_o`=2'b11, `cfg_rst_o`=1, `mode_irq_o`=0 and `wdt_en_o`=0.
- R2: A rising edge with `reset_pin_i` high puts the block in the held state from that edge on, whatever the other inputs are. The held state has `wake_o`=0, `mode_o`=2'b11 and `cfg_rst_o`=1.
- R3: With synchronized power good, `wake_o` rises at the RST_CYCLES-th consecutive edge (default 4100) that samples `reset_pin_i` low. The mode becomes MISSION (2'b00) with `pll_ok_o`=1.
- R4: With synchronized power absent and the battery present, the block leaves the held state at the NOPWR_CYCLES-th such edge (default 2). It enters BROWNOUT (2'b01) with `wake_o`=1 and `pll_ok_o`=0.
- R5: When power is lost in MISSION with the battery present, the block enters BROWNOUT. `pll_ok_o` drops at that edge and `wake_o` stays 1.
- R6: When power is lost with no battery, the block enters SLEEP (2'b11) with `wake_o`=0 and `cfg_rst_o`=1.
- R7: From BROWNOUT, SLEEP or LCD, MISSION is entered at the LOCK_CYCLES-th consecutive edge (default 3000, legal range 2048 to 4096) that sees synchronized power good. If power drops first, the count restarts. `pll_ok_o` stays 0 until that edge.
- R8: On a BROWNOUT-to-MISSION change, `mode_irq_o` is high for exactly one cycle and `cfg_rst_o` stays 0. `mode_irq_o` is never high at any other time.
- R9: On a change from SLEEP or LCD to MISSION, no interrupt is raised.
- R10: `wdt_en_o` is set on entry to MISSION and survives a MISSION-to-BROWNOUT change. It is cleared whenever `wake_o` is low. It is 0 in a BROWNOUT entered directly from reset.
- R11: In BROWNOUT with power not good and the battery present, `lcd_req_i`=1 moves the block to LCD (2'b10, `wake_o`=0) at the next edge. In MISSION the request has no effect and the mode stays 2'b00.
- R12: When the synchronized battery flag goes to 0 in BROWNOUT while power is not good, the block enters SLEEP.
- R13: A change on `pwr_good_i` or `batt_ok_i` first affects the mode at the third rising edge after it.
- R14: `cfg_rst_o` is 1 exactly when `wake_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32 kHz timebase clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reset_pin_i | input | 1 | External reset pin, active high |
| pwr_good_i | input | 1 | Power-fault comparator output, 1 = system power good |
| batt_ok_i | input | 1 | Backup battery present |
| lcd_req_i | input | 1 | Request to enter LCD mode |
| wake_o | output | 1 | Processor may run |
| pll_ok_o | output | 1 | PLL lock reached, full power |
| mode_o | output | 2 | 00 MISSION, 01 BROWNOUT, 10 LCD, 11 SLEEP or held |
| cfg_rst_o | output | 1 | Configuration registers held at defaults |
| mode_irq_o | output | 1 | One-cycle pulse on return from BROWNOUT to MISSION |
| wdt_en_o | output | 1 | Hardware watchdog enable |

## Verification
The mode choice is tried with every pairing of power and battery that matters:
- Power good with battery present, and power absent with battery present, at reset release. This separates the long reset timer from the short one.
- Power loss with and without battery. This separates BROWNOUT from SLEEP and shows whether the watchdog enable is kept or cleared.
- Power return after BROWNOUT, after SLEEP and after LCD. This shows whether the interrupt belongs only to the BROWNOUT path.
- A power glitch part-way through the lock count. This tells a restarting counter from one that resumes.

Sampling the mode exactly two and three edges after an input change pins down the synchronizer depth.

// File: rtl/pms_pkg.sv
// Package: shared types and encodings of the power mode sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package pms_pkg;

    // Internal sequencer states; the mode code seen outside is derived.
    typedef enum logic [2:0] {
        ST_HOLD     = 3'd0,
        ST_MISSION  = 3'd1,
        ST_BROWNOUT = 3'd2,
        ST_LCD      = 3'd3,
        ST_SLEEP    = 3'd4
    } pms_state_e;

    // Which terminal count the shared timer compares against.
    typedef enum logic [1:0] {
        LIM_RST   = 2'd0,
        LIM_NOPWR = 2'd1,
        LIM_LOCK  = 2'd2
    } pms_lim_e;

    // External mode codes.
    localparam logic [1:0] MODE_MISSION  = 2'b00;
    localparam logic [1:0] MODE_BROWNOUT = 2'b01;
    localparam logic [1:0] MODE_LCD      = 2'b10;
    localparam logic [1:0] MODE_SLEEP    = 2'b11;

    // Map a state to its external mode code; the held state reads as SLEEP.
    function automatic logic [1:0] mode_of(input pms_state_e s);
        logic [1:0] m;
        unique case (s)
            ST_MISSION:  m = MODE_MISSION;
            ST_BROWNOUT: m = MODE_BROWNOUT;
            ST_LCD:      m = MODE_LCD;
            default:     m = MODE_SLEEP;
        endcase
        return m;
    endfunction

    // True for states in which the processor is running.
    function automatic logic is_awake(input pms_state_e s);
        return (s == ST_MISSION) || (s == ST_BROWNOUT);
    endfunction

endpackage

// File: rtl/pms_sync.sv
// Module: multi-stage synchronizer for slow asynchronous level inputs.
// Assumes: inputs are levels that stay stable for several clocks;
//          STAGES >= 1; every stage resets to zero.
module pms_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    generate
        if (STAGES == 1) begin : g_single
            logic [WIDTH-1:0] stage_q;

            // Single capture flop.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q <= '0;
                else        stage_q <= d_i;
            end

            assign q_o = stage_q;
        end else begin : g_chain
            logic [STAGES-1:0][WIDTH-1:0] stage_q;

            // Shift chain: stage 0 captures, the last stage feeds the output.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q <= '0;
                else        stage_q <= {stage_q[STAGES-2:0], d_i};
            end

            assign q_o = stage_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/pms_timer.sv
// Module: shared cycle counter for the reset-release and PLL-lock delays.
// Assumes: the selected limit is at least 1; clear has priority over
//          enable; the counter holds at its terminal value while enabled.
module pms_timer
    import pms_pkg::*;
#(
    parameter int CNT_W        = 13,
    parameter int RST_CYCLES   = 4100,
    parameter int NOPWR_CYCLES = 2,
    parameter int LOCK_CYCLES  = 3000
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clr_i,
    input  logic     en_i,
    input  pms_lim_e lim_sel_i,
    output logic     done_o
);

    localparam logic [CNT_W-1:0] RST_LAST   = CNT_W'(RST_CYCLES - 1);
    localparam logic [CNT_W-1:0] NOPWR_LAST = CNT_W'(NOPWR_CYCLES - 1);
    localparam logic [CNT_W-1:0] LOCK_LAST  = CNT_W'(LOCK_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;

    // Pick the terminal count for the delay currently being timed.
    always_comb begin
        unique case (lim_sel_i)
            LIM_RST:   last = RST_LAST;
            LIM_NOPWR: last = NOPWR_LAST;
            default:   last = LOCK_LAST;
        endcase
    end

    // Done once the count has reached the terminal value; a limit that
    // shrinks mid-count also ends the delay at once.
    assign done_o = (cnt_q >= last);

    // Count enabled cycles; clear restarts the delay.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)        cnt_q <= '0;
        else if (en_i && !done_o)   cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/pms_fsm.sv
// Module: mode state machine of the power sequencer.
// Assumes: pwr_good_i and batt_ok_i are already synchronized;
//          reset_pin_i and lcd_req_i are stable around the clock edge;
//          tmr_done_i is the combinational done of the shared timer.
module pms_fsm
    import pms_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reset_pin_i,
    input  logic       pwr_good_i,
    input  logic       batt_ok_i,
    input  logic       lcd_req_i,
    input  logic       tmr_done_i,
    output pms_state_e state_o,
    output logic       tmr_clr_o,
    output logic       tmr_en_o,
    output pms_lim_e   lim_sel_o,
    output logic       irq_o,
    output logic       wdt_en_o
);

    pms_state_e state_q, state_d;
    logic       irq_q, wdt_q;
    logic       enter_mission;
    logic       drop_wake;

    // Next state and timer control.
    always_comb begin
        state_d   = state_q;
        tmr_en_o  = 1'b0;
        tmr_clr_o = 1'b1;
        lim_sel_o = LIM_LOCK;
        if (reset_pin_i) begin
            state_d = ST_HOLD;
        end else begin
            unique case (state_q)
                ST_HOLD: begin
                    tmr_en_o  = 1'b1;
                    tmr_clr_o = 1'b0;
                    lim_sel_o = pwr_good_i ? LIM_RST : LIM_NOPWR;
                    if (tmr_done_i) begin
                        if (pwr_good_i) begin
                            state_d   = ST_MISSION;
                            tmr_clr_o = 1'b1;
                        end else if (batt_ok_i) begin
                            state_d   = ST_BROWNOUT;
                            tmr_clr_o = 1'b1;
                        end
                    end
                end
                ST_MISSION: begin
                    if (!pwr_good_i) begin
                        state_d = batt_ok_i ? ST_BROWNOUT : ST_SLEEP;
                    end
                end
                ST_BROWNOUT: begin
                    if (pwr_good_i) begin
                        tmr_en_o  = 1'b1;
                        tmr_clr_o = 1'b0;
                        if (tmr_done_i) begin
                            state_d   = ST_MISSION;
                            tmr_clr_o = 1'b1;
                        end
                    end else if (!batt_ok_i) begin
                        state_d = ST_SLEEP;
                    end else if (lcd_req_i) begin
                        state_d = ST_LCD;
                    end
                end
                ST_LCD, ST_SLEEP: begin
                    if (pwr_good_i) begin
                        tmr_en_o  = 1'b1;
                        tmr_clr_o = 1'b0;
                        if (tmr_done_i) begin
                            state_d   = ST_MISSION;
                            tmr_clr_o = 1'b1;
                        end
                    end
                end
                default: begin
                    state_d = ST_HOLD;
                end
            endcase
        end
    end

    assign enter_mission = (state_d == ST_MISSION) && (state_q != ST_MISSION);
    assign drop_wake     = !is_awake(state_d);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    // One-cycle interrupt on the return from battery to full power.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= (state_q == ST_BROWNOUT) && (state_d == ST_MISSION);
    end

    // Watchdog enable: set on MISSION entry, cleared whenever wake drops.
    always_ff @(posedge clk) begin
        if (!rst_n)             wdt_q <= 1'b0;
        else if (drop_wake)     wdt_q <= 1'b0;
        else if (enter_mission) wdt_q <= 1'b1;
    end

    assign state_o  = state_q;
    assign irq_o    = irq_q;
    assign wdt_en_o = wdt_q;

endmodule

// File: rtl/pwr_mode_seq.sv
// Module: power mode and reset sequencer (top).
// Selects MISSION, BROWNOUT, LCD or SLEEP from the reset pin, the
// power-good comparator and the battery flag, and times reset release
// and PLL lock in cycles of the 32 kHz clock.
// Assumes: clk is the always-running 32 kHz timebase; rst_n is
//          synchronous; LOCK_CYCLES lies within 2048..4096.
module pwr_mode_seq
    import pms_pkg::*;
#(
    parameter int RST_CYCLES   = 4100,
    parameter int NOPWR_CYCLES = 2,
    parameter int LOCK_CYCLES  = 3000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reset_pin_i,
    input  logic       pwr_good_i,
    input  logic       batt_ok_i,
    input  logic       lcd_req_i,
    output logic       wake_o,
    output logic       pll_ok_o,
    output logic [1:0] mode_o,
    output logic       cfg_rst_o,
    output logic       mode_irq_o,
    output logic       wdt_en_o
);

    localparam int MAX_A  = (RST_CYCLES > LOCK_CYCLES) ? RST_CYCLES : LOCK_CYCLES;
    localparam int MAX_CY = (MAX_A > NOPWR_CYCLES) ? MAX_A : NOPWR_CYCLES;
    localparam int CNT_W  = $clog2(MAX_CY + 1);

    logic [1:0] raw_status;
    logic [1:0] sync_status;
    logic       pwr_good_s;
    logic       batt_ok_s;
    logic       tmr_clr, tmr_en, tmr_done;
    pms_lim_e   lim_sel;
    pms_state_e state;

    assign raw_status = {batt_ok_i, pwr_good_i};
    assign pwr_good_s = sync_status[0];
    assign batt_ok_s  = sync_status[1];

    pms_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_status),
        .q_o   (sync_status)
    );

    pms_timer #(
        .CNT_W        (CNT_W),
        .RST_CYCLES   (RST_CYCLES),
        .NOPWR_CYCLES (NOPWR_CYCLES),
        .LOCK_CYCLES  (LOCK_CYCLES)
    ) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (tmr_clr),
        .en_i      (tmr_en),
        .lim_sel_i (lim_sel),
        .done_o    (tmr_done)
    );

    pms_fsm i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .reset_pin_i (reset_pin_i),
        .pwr_good_i  (pwr_good_s),
        .batt_ok_i   (batt_ok_s),
        .lcd_req_i   (lcd_req_i),
        .tmr_done_i  (tmr_done),
        .state_o     (state),
        .tmr_clr_o   (tmr_clr),
        .tmr_en_o    (tmr_en),
        .lim_sel_o   (lim_sel),
        .irq_o       (mode_irq_o),
        .wdt_en_o    (wdt_en_o)
    );

    // Decode the externally visible status from the registered state.
    always_comb begin
        wake_o    = is_awake(state);
        pll_ok_o  = (state == ST_MISSION);
        mode_o    = mode_of(state);
        cfg_rst_o = !is_awake(state);
    end

endmodule

// File: rtl/pwr_mode_seq_chk.sv
// Module: assertion checker for pwr_mode_seq, attached by bind.
// Assumes: observes only the top-level ports.
module pwr_mode_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reset_pin_i,
    input logic       wake_o,
    input logic       pll_ok_o,
    input logic [1:0] mode_o,
    input logic       cfg_rst_o,
    input logic       mode_irq_o,
    input logic       wdt_en_o
);

    // R2
    reset_pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_pin_i |=> (!wake_o && mode_o == 2'b11));

    // R14
    cfg_follows_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rst_o != wake_o);

    // R8
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_irq_o |=> !mode_irq_o);

    // R8
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_irq_o |-> (mode_o == 2'b00 && $past(mode_o) == 2'b01));

    // R5
    pll_only_mission_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pll_ok_o |-> (mode_o == 2'b00 && wake_o));

    // R10
    wdt_needs_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wake_o |-> !wdt_en_o);

    // R11
    lcd_asleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b10) |-> (!wake_o && !pll_ok_o));

    // R7
    pll_rise_from_mission_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_ok_o) |-> $past(mode_o) != 2'b00);

endmodule

bind pwr_mode_seq pwr_mode_seq_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reset_pin_i (reset_pin_i),
    .wake_o      (wake_o),
    .pll_ok_o    (pll_ok_o),
    .mode_o      (mode_o),
    .cfg_rst_o   (cfg_rst_o),
    .mode_irq_o  (mode_irq_o),
    .wdt_en_o    (wdt_en_o)
);

// File: tb/test_pwr_mode_seq.sv
// Bench: behavioural reference model compared on every clock, plus
// directed checks at the timing boundaries.
module test_pwr_mode_seq;

    localparam int RSTC  = 4100;
    localparam int NOPC  = 2;
    localparam int LOCKC = 3000;

    // Model state codes.
    localparam int M_HOLD = 0, M_MIS = 1, M_BRN = 2, M_LCD = 3, M_SLP = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reset_pin_i = 1'b1;
    logic       pwr_good_i = 1'b1;
    logic       batt_ok_i = 1'b1;
    logic       lcd_req_i = 1'b0;
    logic       wake_o, pll_ok_o, cfg_rst_o, mode_irq_o, wdt_en_o;
    logic [1:0] mode_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    pwr_mode_seq i_pwr_mode_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .reset_pin_i (reset_pin_i),
        .pwr_good_i  (pwr_good_i),
        .batt_ok_i   (batt_ok_i),
        .lcd_req_i   (lcd_req_i),
        .wake_o      (wake_o),
        .pll_ok_o    (pll_ok_o),
        .mode_o      (mode_o),
        .cfg_rst_o   (cfg_rst_o),
        .mode_irq_o  (mode_irq_o),
        .wdt_en_o    (wdt_en_o)
    );

    task automatic chk(input string tag, input logic [1:0] got, input logic [1:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    // Reference model: power/battery delay queues and mode bookkeeping.
    bit pg_q[$] = '{0, 0};
    bit bt_q[$] = '{0, 0};
    int m_st = M_HOLD, m_k = 0;
    bit m_wdt = 0, m_irq = 0;

    always @(posedge clk) begin
        bit pg, bt;
        int lim;
        if (!rst_n) begin
            pg_q = '{0, 0}; bt_q = '{0, 0};
            m_st = M_HOLD; m_k = 0; m_wdt = 0; m_irq = 0;
        end else begin
            pg = pg_q.pop_front(); pg_q.push_back(pwr_good_i);
            bt = bt_q.pop_front(); bt_q.push_back(batt_ok_i);
            m_irq = 0;
            if (reset_pin_i) begin
                m_st = M_HOLD; m_k = 0;
            end else begin
                case (m_st)
                    M_HOLD: begin
                        lim = pg ? RSTC : NOPC;
                        if (m_k < lim) m_k++;
                        if (m_k >= lim) begin
                            if (pg)      begin m_st = M_MIS; m_k = 0; m_wdt = 1; end
                            else if (bt) begin m_st = M_BRN; m_k = 0; end
                        end
                    end
                    M_MIS: if (!pg) begin m_st = bt ? M_BRN : M_SLP; m_k = 0; end
                    M_BRN: begin
                        if (pg) begin
                            m_k++;
                            if (m_k >= LOCKC) begin m_st = M_MIS; m_k = 0; m_wdt = 1; m_irq = 1; end
                        end else begin
                            m_k = 0;
                            if (!bt)            m_st = M_SLP;
                            else if (lcd_req_i) m_st = M_LCD;
                        end
                    end
                    default: begin
                        if (pg) begin
                            m_k++;
                            if (m_k >= LOCKC) begin m_st = M_MIS; m_k = 0; m_wdt = 1; end
                        end else m_k = 0;
                    end
                endcase
            end
            if (m_st == M_HOLD || m_st == M_SLP || m_st == M_LCD) m_wdt = 0;
        end
    end

    // Compare every output against the model away from the active edge.
    always @(negedge clk) begin
        bit ew;
        logic [1:0] em;
        if (rst_n && !done) begin
            ew = (m_st == M_MIS) || (m_st == M_BRN);
            em = (m_st == M_MIS) ? 2'b00 : (m_st == M_BRN) ? 2'b01 :
                 (m_st == M_LCD) ? 2'b10 : 2'b11;
            chk("R3 model wake", {1'b0, wake_o}, {1'b0, ew});
            chk("R7 model pll_ok", {1'b0, pll_ok_o}, {1'b0, m_st == M_MIS});
            chk("R5 model mode", mode_o, em);
            chk("R14 model cfg_rst", {1'b0, cfg_rst_o}, {1'b0, !ew});
            chk("R8 model irq", {1'b0, mode_irq_o}, {1'b0, m_irq});
            chk("R10 model wdt_en", {1'b0, wdt_en_o}, {1'b0, m_wdt});
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        summary();
    end

    initial begin
        step(4);
        // R1 reset state
        chk("R1 wake", {1'b0, wake_o}, 2'b00);
        chk("R1 pll_ok", {1'b0, pll_ok_o}, 2'b00);
        chk("R1 mode", mode_o, 2'b11);
        chk("R1 cfg_rst", {1'b0, cfg_rst_o}, 2'b01);
        chk("R1 irq", {1'b0, mode_irq_o}, 2'b00);
        chk("R1 wdt", {1'b0, wdt_en_o}, 2'b00);
        rst_n = 1'b1;
        step(6);
        chk("R2 held by pin", mode_o, 2'b11);
        // R3 long release with power
        reset_pin_i = 1'b0;
        step(RSTC - 1);
        chk("R3 before limit", {1'b0, wake_o}, 2'b00);
        step(1);
        chk("R3 wake at limit", {1'b0, wake_o}, 2'b01);
        chk("R3 mission", mode_o, 2'b00);
        chk("R10 wdt on mission", {1'b0, wdt_en_o}, 2'b01);
        // R11 request ignored in MISSION
        lcd_req_i = 1'b1;
        step(10);
        chk("R11 ignored in mission", mode_o, 2'b00);
        lcd_req_i = 1'b0;
        // R13 / R5 power loss with battery
        pwr_good_i = 1'b0;
        step(2);
        chk("R13 not yet seen", mode_o, 2'b00);
        step(1);
        chk("R5 brownout", mode_o, 2'b01);
        chk("R5 pll cleared", {1'b0, pll_ok_o}, 2'b00);
        chk("R10 wdt kept", {1'b0, wdt_en_o}, 2'b01);
        // R7 glitch restarts the lock count
        pwr_good_i = 1'b1;
        step(1000);
        pwr_good_i = 1'b0;
        step(5);
        chk("R7 still brownout", mode_o, 2'b01);
        pwr_good_i = 1'b1;
        step(LOCKC + 1);
        chk("R7 before lock", {1'b0, pll_ok_o}, 2'b00);
        step(1);
        chk("R7 locked", {1'b0, pll_ok_o}, 2'b01);
        chk("R8 irq pulse", {1'b0, mode_irq_o}, 2'b01);
        step(1);
        chk("R8 irq ends", {1'b0, mode_irq_o}, 2'b00);
        // R6 loss without battery
        pwr_good_i = 1'b0; batt_ok_i = 1'b0;
        step(3);
        chk("R6 sleep", mode_o, 2'b11);
        chk("R6 cfg_rst", {1'b0, cfg_rst_o}, 2'b01);
        chk("R10 wdt cleared", {1'b0, wdt_en_o}, 2'b00);
        // R9 return from SLEEP
        pwr_good_i = 1'b1;
        step(LOCKC + 2);
        chk("R9 mission from sleep", mode_o, 2'b00);
        chk("R9 no irq", {1'b0, mode_irq_o}, 2'b00);
        // R11 LCD from BROWNOUT
        batt_ok_i = 1'b1; pwr_good_i = 1'b0;
        step(3);
        chk("R5 brownout again", mode_o, 2'b01);
        lcd_req_i = 1'b1;
        step(1);
        chk("R11 lcd", mode_o, 2'b10);
        lcd_req_i = 1'b0;
        step(5);
        chk("R11 lcd stays", mode_o, 2'b10);
        pwr_good_i = 1'b1;
        step(LOCKC + 2);
        chk("R9 mission from lcd", mode_o, 2'b00);
        chk("R9 no irq from lcd", {1'b0, mode_irq_o}, 2'b00);
        // R12 battery lost in BROWNOUT
        pwr_good_i = 1'b0;
        step(3);
        batt_ok_i = 1'b0;
        step(2);
        chk("R13 battery not yet seen", mode_o, 2'b01);
        step(1);
        chk("R12 sleep on battery loss", mode_o, 2'b11);
        // R4 short release without power
        batt_ok_i = 1'b1; reset_pin_i = 1'b1;
        step(4);
        chk("R2 pin held", mode_o, 2'b11);
        reset_pin_i = 1'b0;
        step(1);
        chk("R4 one edge", {1'b0, wake_o}, 2'b00);
        step(1);
        chk("R4 brownout", mode_o, 2'b01);
        chk("R4 no pll", {1'b0, pll_ok_o}, 2'b00);
        chk("R10 no wdt from reset", {1'b0, wdt_en_o}, 2'b00);
        // R2 pin during MISSION
        pwr_good_i = 1'b1;
        step(LOCKC + 2);
        chk("R7 mission", mode_o, 2'b00);
        reset_pin_i = 1'b1;
        step(1);
        chk("R2 pin stops", {1'b0, wake_o}, 2'b00);
        chk("R14 cfg_rst", {1'b0, cfg_rst_o}, 2'b01);
        reset_pin_i = 1'b0;
        step(RSTC);
        chk("R3 second release", mode_o, 2'b00);
        summary();
    end

endmodule